// File: doc/BRIEF.md
# Pipeline Bypass and Hazard Controller

This block is the operand-steering and flow-control logic for a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. Each cycle it looks at the two source register numbers of the instruction in decode. It also looks at the destination number, write-enable and load flag of the instructions now in execute, memory and writeback. For each operand it picks where the value comes from: the register file, or a bypass from one of the three later stages. When several later stages write the same register, the youngest one wins.

A load's data exists only once the load reaches writeback. If the youngest producer of a decode operand is a load still in execute or memory, the block stalls. It holds the program counter and the decode instruction, and sends a bubble into execute. Every branch is predicted not taken. When execute reports a taken branch, the block annuls the two younger instructions in fetch and decode and redirects fetch to the branch target. An annul in the same cycle as a stall wins over the stall, because the stalled decode instruction is discarded anyway.

The block is purely combinational. The pipeline registers, register file, ALU and bypass multiplexers sit in the datapath around it. All pins are plain control signals. There is no streaming interface, so there is no back-pressure to describe.

Top module: `hz_bypass_ctl`

## Requirements
- R1: For each source, `byp_sel_o` uses this code: 0 = register file, 1 = execute stage, 2 = memory stage, 3 = writeback stage. A stage is a candidate when its write-enable is 1 and its destination equals the source number.
- R2: When more than one stage is a candidate, the youngest wins: execute beats memory, and memory beats writeback.
- R3: A source number of 0 always selects code 0, even when a stage writes register 0.
- R4: A source with no candidate stage selects code 0.
- R5: If a source's winning candidate is a load in execute, `stall_o` is 1.
- R6: If a source's winning candidate is a load in memory, `stall_o` is 1.
- R7: A load in writeback is bypassed with code 3 and causes no stall.
- R8: A non-load in execute that writes the same register as a load in memory shadows it. The select is 1 and there is no stall.
- R9: When `exe_br_taken_i` is 1, `annul_o` and `redirect_o` are 1 and `redirect_pc_o` equals `exe_br_target_i`. Otherwise all three are 0.
- R10: When a taken branch and a load-use hazard occur in the same cycle, `stall_o` is 0 and `annul_o` is 1.
- R11: `exe_bubble_o` is 1 exactly when a stall or an annul is in effect.
- R12: A stage whose write-enable is 0 is never a candidate, even if its destination matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs_i | input | NUM_SRC x REG_AW | Source register numbers of the decode instruction |
| exe_rd_i | input | REG_AW | Destination register of the execute instruction |
| exe_we_i | input | 1 | Execute instruction writes a register |
| exe_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | REG_AW | Destination register of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | REG_AW | Destination register of the writeback instruction |
| wb_we_i | input | 1 | Writeback instruction writes a register |
| exe_br_taken_i | input | 1 | Branch in execute resolved taken |
| exe_br_target_i | input | PC_W | Target of the taken branch |
| byp_sel_o | output | NUM_SRC x 2 | Operand source select per decode source |
| stall_o | output | 1 | Hold PC and decode instruction |
| exe_bubble_o | output | 1 | Replace next execute instruction with a bubble |
| annul_o | output | 1 | Squash the instructions in fetch and decode |
| redirect_o | output | 1 | Load the fetch PC from `redirect_pc_o` |
| redirect_pc_o | output | PC_W | Redirect target |

## Verification
The bench builds the cases where stages compete for the same register. In one, all three stages write the register a source needs. In another, a non-load in execute hides a load in memory. A wrong priority order would forward stale data, and a design that ignores shadowing would stall when it does not need to. It also drives loads in each of execute, memory and writeback. A design that forwards a load from execute or memory would hand over data that does not exist yet, and one that stalls on a writeback load would lose cycles for nothing. Register 0, matches with write-enable cleared, and a taken branch that lands on a load-use hazard cover the remaining corners. A wrong design there would forward a zero-register write, forward from an instruction that does not write, or freeze the pipeline while discarding the instruction it holds.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EXE = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } byp_src_e;

endpackage

// File: rtl/hz_src_select.sv
module hz_src_select
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs_i,
  input  logic [REG_AW-1:0] exe_rd_i,
  input  logic              exe_we_i,
  input  logic              exe_load_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic              mem_load_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output byp_src_e          sel_o,
  output logic              load_wait_o
);

  logic rs_live;
  logic hit_exe, hit_mem, hit_wb;

  assign rs_live = (rs_i != '0);
  assign hit_exe = rs_live && exe_we_i && (exe_rd_i == rs_i);
  assign hit_mem = rs_live && mem_we_i && (mem_rd_i == rs_i);
  assign hit_wb  = rs_live && wb_we_i  && (wb_rd_i  == rs_i);

  always_comb begin
    sel_o       = SRC_RF;
    load_wait_o = 1'b0;
    if (hit_exe) begin
      sel_o       = SRC_EXE;
      load_wait_o = exe_load_i;
    end else if (hit_mem) begin
      sel_o       = SRC_MEM;
      load_wait_o = mem_load_i;
    end else if (hit_wb) begin
      sel_o       = SRC_WB;
    end
  end

endmodule

// File: rtl/hz_flow_ctl.sv
module hz_flow_ctl #(
  parameter int NUM_SRC = 2,
  parameter int PC_W    = 32
) (
  input  logic [NUM_SRC-1:0] load_wait_i,
  input  logic               br_taken_i,
  input  logic [PC_W-1:0]    br_target_i,
  output logic               stall_o,
  output logic               bubble_o,
  output logic               annul_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o
);

  logic any_wait;

  assign any_wait      = |load_wait_i;
  assign annul_o       = br_taken_i;
  assign redirect_o    = br_taken_i;
  assign redirect_pc_o = br_taken_i ? br_target_i : '0;
  assign stall_o       = any_wait && !br_taken_i;
  assign bubble_o      = any_wait || br_taken_i;

endmodule

// File: rtl/hz_bypass_ctl.sv
module hz_bypass_ctl
  import hz_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2,
  parameter int PC_W    = 32
) (
  input  logic [NUM_SRC-1:0][REG_AW-1:0] dec_rs_i,
  input  logic [REG_AW-1:0]              exe_rd_i,
  input  logic                           exe_we_i,
  input  logic                           exe_load_i,
  input  logic [REG_AW-1:0]              mem_rd_i,
  input  logic                           mem_we_i,
  input  logic                           mem_load_i,
  input  logic [REG_AW-1:0]              wb_rd_i,
  input  logic                           wb_we_i,
  input  logic                           exe_br_taken_i,
  input  logic [PC_W-1:0]                exe_br_target_i,
  output logic [NUM_SRC-1:0][1:0]        byp_sel_o,
  output logic                           stall_o,
  output logic                           exe_bubble_o,
  output logic                           annul_o,
  output logic                           redirect_o,
  output logic [PC_W-1:0]                redirect_pc_o
);

  logic [NUM_SRC-1:0] load_wait;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    byp_src_e sel;
    hz_src_select #(.REG_AW(REG_AW)) u_sel (
      .rs_i        (dec_rs_i[s]),
      .exe_rd_i    (exe_rd_i),
      .exe_we_i    (exe_we_i),
      .exe_load_i  (exe_load_i),
      .mem_rd_i    (mem_rd_i),
      .mem_we_i    (mem_we_i),
      .mem_load_i  (mem_load_i),
      .wb_rd_i     (wb_rd_i),
      .wb_we_i     (wb_we_i),
      .sel_o       (sel),
      .load_wait_o (load_wait[s])
    );
    assign byp_sel_o[s] = sel;
  end

  hz_flow_ctl #(.NUM_SRC(NUM_SRC), .PC_W(PC_W)) u_flow (
    .load_wait_i   (load_wait),
    .br_taken_i    (exe_br_taken_i),
    .br_target_i   (exe_br_target_i),
    .stall_o       (stall_o),
    .bubble_o      (exe_bubble_o),
    .annul_o       (annul_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );

endmodule

// File: rtl/hz_bypass_ctl_chk.sv
module hz_bypass_ctl_chk #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2,
  parameter int PC_W    = 32
) (
  input  logic [NUM_SRC-1:0][REG_AW-1:0] dec_rs_i,
  input  logic [REG_AW-1:0]              exe_rd_i,
  input  logic                           exe_we_i,
  input  logic                           exe_load_i,
  input  logic [REG_AW-1:0]              mem_rd_i,
  input  logic                           mem_we_i,
  input  logic                           mem_load_i,
  input  logic [REG_AW-1:0]              wb_rd_i,
  input  logic                           wb_we_i,
  input  logic                           exe_br_taken_i,
  input  logic [PC_W-1:0]                exe_br_target_i,
  input  logic [NUM_SRC-1:0][1:0]        byp_sel_o,
  input  logic                           stall_o,
  input  logic                           exe_bubble_o,
  input  logic                           annul_o,
  input  logic                           redirect_o,
  input  logic [PC_W-1:0]                redirect_pc_o
);

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      // R3
      zero_reg_chk: assert (dec_rs_i[s] != '0 || byp_sel_o[s] == 2'd0);
      // R12
      exe_sel_valid_chk: assert (byp_sel_o[s] != 2'd1 || (exe_we_i && exe_rd_i == dec_rs_i[s]));
      // R2
      mem_not_shadowed_chk: assert (byp_sel_o[s] != 2'd2 ||
        (mem_we_i && mem_rd_i == dec_rs_i[s] && !(exe_we_i && exe_rd_i == dec_rs_i[s])));
      // R5
      exe_load_stall_chk: assert (!(byp_sel_o[s] == 2'd1 && exe_load_i && !exe_br_taken_i) || stall_o);
      // R6
      mem_load_stall_chk: assert (!(byp_sel_o[s] == 2'd2 && mem_load_i && !exe_br_taken_i) || stall_o);
    end
    // R10
    annul_over_stall_chk: assert (!(stall_o && annul_o));
    // R11
    bubble_cover_chk: assert (exe_bubble_o == (stall_o || annul_o));
    // R9
    redirect_pair_chk: assert (redirect_o == annul_o && annul_o == exe_br_taken_i);
    // R9
    redirect_pc_chk: assert (!redirect_o || redirect_pc_o == exe_br_target_i);
  end

endmodule

bind hz_bypass_ctl hz_bypass_ctl_chk #(
  .REG_AW(REG_AW), .NUM_SRC(NUM_SRC), .PC_W(PC_W)
) u_chk (.*);

// File: tb/hz_bypass_ctl_tb.sv
module hz_bypass_ctl_tb;

  localparam int REG_AW  = 5;
  localparam int NUM_SRC = 2;
  localparam int PC_W    = 32;

  typedef struct packed {
    logic [1:0]      sel1;
    logic [1:0]      sel0;
    logic            stall;
    logic            bubble;
    logic            annul;
    logic            redirect;
    logic [PC_W-1:0] rpc;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NUM_SRC-1:0][REG_AW-1:0] dec_rs;
  logic [REG_AW-1:0] exe_rd, mem_rd, wb_rd;
  logic exe_we, exe_load, mem_we, mem_load, wb_we, br_taken;
  logic [PC_W-1:0] br_target;
  logic [NUM_SRC-1:0][1:0] byp_sel;
  logic stall, bubble, annul, redirect;
  logic [PC_W-1:0] redirect_pc;

  hz_bypass_ctl #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC), .PC_W(PC_W)) u_dut (
    .dec_rs_i(dec_rs), .exe_rd_i(exe_rd), .exe_we_i(exe_we), .exe_load_i(exe_load),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_load_i(mem_load),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .exe_br_taken_i(br_taken), .exe_br_target_i(br_target),
    .byp_sel_o(byp_sel), .stall_o(stall), .exe_bubble_o(bubble),
    .annul_o(annul), .redirect_o(redirect), .redirect_pc_o(redirect_pc)
  );

  exp_t  exp_q[$];
  string tag_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference from the requirement text: code 0 RF, 1 EXE, 2 MEM, 3 WB,
  // youngest candidate wins, x0 never bypassed, loads wait unless in WB.
  function automatic void ref_src(input logic [REG_AW-1:0] rs,
                                  output logic [1:0] sel, output logic wait_ld);
    sel = 2'd0;
    wait_ld = 1'b0;
    if (rs != 0) begin
      if (exe_we && exe_rd == rs) begin
        sel = 2'd1; wait_ld = exe_load;
      end else if (mem_we && mem_rd == rs) begin
        sel = 2'd2; wait_ld = mem_load;
      end else if (wb_we && wb_rd == rs) begin
        sel = 2'd3;
      end
    end
  endfunction

  task automatic drive(input string tag,
                       input logic [REG_AW-1:0] rs0, input logic [REG_AW-1:0] rs1,
                       input logic [REG_AW-1:0] erd, input logic ewe, input logic eld,
                       input logic [REG_AW-1:0] mrd, input logic mwe, input logic mld,
                       input logic [REG_AW-1:0] wrd, input logic wwe,
                       input logic tk, input logic [PC_W-1:0] tgt);
    exp_t e;
    logic w0, w1;
    @(posedge clk);
    #1;
    dec_rs[0] = rs0; dec_rs[1] = rs1;
    exe_rd = erd; exe_we = ewe; exe_load = eld;
    mem_rd = mrd; mem_we = mwe; mem_load = mld;
    wb_rd = wrd; wb_we = wwe;
    br_taken = tk; br_target = tgt;
    ref_src(rs0, e.sel0, w0);
    ref_src(rs1, e.sel1, w1);
    e.annul    = tk;
    e.redirect = tk;
    e.rpc      = tk ? tgt : '0;
    e.stall    = (w0 || w1) && !tk;
    e.bubble   = w0 || w1 || tk;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a.sel0 = byp_sel[0]; a.sel1 = byp_sel[1];
        a.stall = stall; a.bubble = bubble; a.annul = annul;
        a.redirect = redirect; a.rpc = redirect_pc;
        n_checks++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: actual sel0=%0d sel1=%0d stall=%b bubble=%b annul=%b redir=%b pc=%h expected sel0=%0d sel1=%0d stall=%b bubble=%b annul=%b redir=%b pc=%h",
                   t, a.sel0, a.sel1, a.stall, a.bubble, a.annul, a.redirect, a.rpc,
                   e.sel0, e.sel1, e.stall, e.bubble, e.annul, e.redirect, e.rpc);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    dec_rs = '0; exe_rd = '0; mem_rd = '0; wb_rd = '0;
    exe_we = 0; exe_load = 0; mem_we = 0; mem_load = 0; wb_we = 0;
    br_taken = 0; br_target = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset / idle state: all outputs quiet (R4)
    drive("R4_idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0);
    // R1 single producer in each stage
    drive("R1_exe", 5, 6, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R1_mem", 5, 6, 0, 0, 0, 6, 1, 0, 0, 0, 0, 0);
    drive("R1_wb",  5, 6, 0, 0, 0, 0, 0, 0, 5, 1, 0, 0);
    // R2 priority: all three write x7
    drive("R2_all3", 7, 7, 7, 1, 0, 7, 1, 0, 7, 1, 0, 0);
    drive("R2_memwb", 9, 3, 0, 0, 0, 9, 1, 0, 9, 1, 0, 0);
    // R3 x0 never bypassed
    drive("R3_x0", 0, 0, 0, 1, 1, 0, 1, 1, 0, 1, 0, 0);
    // R4 no match
    drive("R4_nomatch", 11, 12, 13, 1, 1, 14, 1, 1, 15, 1, 0, 0);
    // R5 load in EXE, second source
    drive("R5_exeload", 2, 20, 20, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R6 load in MEM
    drive("R6_memload", 21, 4, 0, 0, 0, 21, 1, 1, 0, 0, 0, 0);
    // R7 load in WB: bypassed, no stall
    drive("R7_wbload", 22, 22, 1, 1, 0, 3, 1, 0, 22, 1, 0, 0);
    // R8 non-load in EXE shadows load in MEM
    drive("R8_shadow", 8, 0, 8, 1, 0, 8, 1, 1, 0, 0, 0, 0);
    // R8 converse: load in EXE shadows non-load in MEM -> stall
    drive("R8_exeload_shadow", 8, 0, 8, 1, 1, 8, 1, 0, 0, 0, 0, 0);
    // R9 taken branch, no hazard
    drive("R9_taken", 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_4A20);
    // R9 not-taken leaves redirect quiet even with a target present
    drive("R9_nottaken", 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'hDEAD_0000);
    // R10 taken branch plus load-use hazard
    drive("R10_annul_wins", 17, 0, 17, 1, 1, 0, 0, 0, 0, 0, 1, 32'h0000_0100);
    // R11 bubble on stall alone, on mixed sources
    drive("R11_bubble", 30, 31, 30, 1, 0, 31, 1, 1, 0, 0, 0, 0);
    // R12 matching destinations with write-enable low
    drive("R12_we_off", 10, 10, 10, 0, 1, 10, 0, 1, 10, 0, 0, 0);
    drive("R12_we_off_wb", 16, 16, 16, 0, 0, 0, 0, 0, 16, 1, 0, 0);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule